// File: doc/BRIEF.md
# USB Host Frame Timer

This block is the frame timing unit of a USB host controller. It counts down the bit times left in the current frame on each bit-time tick. When the count runs out it reloads from a programmable frame interval, advances a 16-bit frame number and emits a start-of-frame pulse. A frame-number-overflow pulse marks every change of the frame number's top bit. Two flags are compared against the remaining time. One tells the scheduler that the periodic part of the frame has been reached. The other tells it whether enough time is left to start a low-speed transaction.

Software programs three values through a small write port. The first is the interval word, which holds the interval, a largest-packet field and a toggle bit. The second is the periodic-start value and the third is the low-speed threshold. Software flips the toggle bit each time it writes a new interval. That bit is copied into the remaining-time word at every reload, so software can see when its new interval took effect. Counting is held frozen while the operational enable is low. Token generation and encoding of the start-of-frame packet are done elsewhere.

Top module: `ufrm_timer`

## Requirements
- R1: After a synchronous active-low reset, the following all read as zero: the remaining word, the frame number, start-of-frame, overflow, the periodic flag and the low-speed flag. The interval word reads as the reset interval (default 11999) with toggle and packet field at zero.
- R2: A write with `wr_sel`=0 loads the interval word. Bits 13:0 are the interval, bits 30:16 are the largest-packet field and bit 31 is the toggle. `interval_rd` returns these fields in the same positions, and bits 15:14 always read as 0.
- R3: A tick while `run_en` is high and the remaining count is 0 reloads the count from the interval and copies the interval toggle into bit 31 of `remain_rd`. It also adds one to the frame number (modulo 2^16). `sof_pulse` is high for exactly the one cycle after that clock edge.
- R4: A tick while `run_en` is high and the remaining count is nonzero lowers bits 13:0 of `remain_rd` by one. A cycle without a tick leaves the count unchanged.
- R5: While `run_en` is low, ticks are ignored: the remaining word and the frame number hold, and no start-of-frame pulse is produced.
- R6: A new interval only takes effect at the next reload, and a write in the middle of a frame leaves the running count and its toggle untouched. When a write and a reload fall on the same edge, the reload uses the interval held before that write.
- R7: `fno_pulse` is high for one cycle after any frame-number update that changes bit 15 of the frame number, that is, on the step to 0x8000 and on the wrap to 0x0000.
- R8: A write with `wr_sel`=1 sets the periodic start from bits 13:0. `periodic_win` is high exactly while the remaining count is strictly less than that value.
- R9: A write with `wr_sel`=2 sets the low-speed threshold from bits 11:0. `ls_ok` is high exactly while the remaining count is strictly greater than that value.
- R10: A write with `wr_sel`=3 changes nothing: the interval word, the periodic start and the low-speed threshold all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Operational enable; counting freezes while low |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 interval, 1 periodic start, 2 low-speed threshold, 3 none |
| wr_data | input | 32 | Write data |
| interval_rd | output | 32 | Interval word: toggle, packet field, interval |
| remain_rd | output | 32 | Remaining word: reload toggle in bit 31, count in bits 13:0 |
| frnum_rd | output | 16 | Frame number |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame-number top-bit change pulse |
| periodic_win | output | 1 | Remaining count is below the periodic start |
| ls_ok | output | 1 | Remaining count is above the low-speed threshold |

## Verification
Two things can fall in the same cycle: a software write of the interval word and the reload that reads it. The bench runs the counter down to zero and, on the very tick that reloads it, writes a different interval with the opposite toggle. It then expects the reload to show the value and toggle written earlier in that frame, and it expects the just-written value only at the following reload. The overflow pulse also coincides with a start-of-frame. The bench provokes this with a zero interval, which gives one frame per tick, and walks the frame number through both top-bit changes.

// File: rtl/ufrm_pkg.sv
`timescale 1ns/1ps
// Shared widths and write-target encoding for the frame timer.
package ufrm_pkg;
    localparam int UF_REG_W = 32;  // software word width
    localparam int UF_CNT_W = 14;  // bit-time counter width
    localparam int UF_MPS_W = 15;  // largest-packet field width
    localparam int UF_FRN_W = 16;  // frame number width
    localparam int UF_LS_W  = 12;  // low-speed threshold width

    typedef enum logic [1:0] {
        SEL_INTERVAL = 2'd0,
        SEL_PSTART   = 2'd1,
        SEL_LSTHR    = 2'd2,
        SEL_NONE     = 2'd3
    } uf_sel_e;
endpackage

// File: rtl/ufrm_cfg_regs.sv
`timescale 1ns/1ps
// Configuration registers: interval word, periodic start, low-speed threshold.
// Assumes the toggle bit is the word's top bit and the packet field sits
// directly below it; writes with an unknown select are dropped.
module ufrm_cfg_regs
    import ufrm_pkg::*;
#(
    parameter int REG_W        = UF_REG_W,
    parameter int CNT_W        = UF_CNT_W,
    parameter int MPS_W        = UF_MPS_W,
    parameter int LS_W         = UF_LS_W,
    parameter int RST_INTERVAL = 11999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [CNT_W-1:0] interval,
    output logic [MPS_W-1:0] max_pkt,
    output logic             intv_tog,
    output logic [CNT_W-1:0] pstart,
    output logic [LS_W-1:0]  ls_thr
);
    localparam int TOG_BIT = REG_W - 1;
    localparam int MPS_LSB = TOG_BIT - MPS_W;
    localparam int GAP_W   = MPS_LSB - CNT_W;

    logic unused_gap;
    assign unused_gap = ^wr_data[MPS_LSB-1 -: GAP_W];

    // Capture software writes into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= CNT_W'(RST_INTERVAL);
            max_pkt  <= '0;
            intv_tog <= 1'b0;
            pstart   <= '0;
            ls_thr   <= '0;
        end else if (wr_en) begin
            case (uf_sel_e'(wr_sel))
                SEL_INTERVAL: begin
                    interval <= wr_data[CNT_W-1:0];
                    max_pkt  <= wr_data[MPS_LSB +: MPS_W];
                    intv_tog <= wr_data[TOG_BIT];
                end
                SEL_PSTART: pstart <= wr_data[CNT_W-1:0];
                SEL_LSTHR:  ls_thr <= wr_data[LS_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ufrm_downcount.sv
`timescale 1ns/1ps
// Bit-time down-counter. Reloads from the interval when a tick finds it at
// zero, copying the interval toggle; otherwise steps down one per tick.
// Assumes bit_tick is a single-cycle strobe.
module ufrm_downcount #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] interval,
    input  logic             intv_tog,
    output logic [CNT_W-1:0] remain,
    output logic             rem_tog,
    output logic             reload_evt,
    output logic             sof_pulse
);
    logic step;
    assign step       = run_en & bit_tick;
    assign reload_evt = step & (remain == '0);

    // Count down, reload at zero, and flag the reload one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            rem_tog   <= 1'b0;
            sof_pulse <= 1'b0;
        end else begin
            sof_pulse <= reload_evt;
            if (reload_evt) begin
                remain  <= interval;
                rem_tog <= intv_tog;
            end else if (step) begin
                remain <= remain - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ufrm_frnum.sv
`timescale 1ns/1ps
// Frame number counter with a pulse whenever its top bit changes.
// Assumes advance is high for one cycle per frame.
module ufrm_frnum #(
    parameter int FRN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [FRN_W-1:0] frnum,
    output logic             fno_pulse
);
    logic [FRN_W-1:0] frnum_nxt;
    assign frnum_nxt = frnum + FRN_W'(1);

    // Advance the frame number and mark top-bit transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frnum     <= '0;
            fno_pulse <= 1'b0;
        end else begin
            fno_pulse <= advance && (frnum_nxt[FRN_W-1] != frnum[FRN_W-1]);
            if (advance) begin
                frnum <= frnum_nxt;
            end
        end
    end
endmodule

// File: rtl/ufrm_cmp.sv
`timescale 1ns/1ps
// Window comparators on the remaining count: periodic-start and low-speed.
// Assumes the threshold is no wider than the counter; it is zero-extended.
module ufrm_cmp #(
    parameter int CNT_W = 14,
    parameter int LS_W  = 12
) (
    input  logic [CNT_W-1:0] remain,
    input  logic [CNT_W-1:0] pstart,
    input  logic [LS_W-1:0]  ls_thr,
    output logic             periodic_win,
    output logic             ls_ok
);
    logic [CNT_W-1:0] ls_ext;

    generate
        if (LS_W < CNT_W) begin : g_ext
            assign ls_ext = {{(CNT_W-LS_W){1'b0}}, ls_thr};
        end else begin : g_same
            assign ls_ext = ls_thr[CNT_W-1:0];
        end
    endgenerate

    // Strict comparisons against the remaining count.
    always_comb begin
        periodic_win = (remain < pstart);
        ls_ok        = (remain > ls_ext);
    end
endmodule

// File: rtl/ufrm_timer.sv
`timescale 1ns/1ps
// Frame timer top: joins the configuration registers, the bit-time counter,
// the frame number counter and the window comparators, and packs the
// software-visible words. Assumes REG_W covers toggle, packet field and count.
module ufrm_timer
    import ufrm_pkg::*;
#(
    parameter int REG_W        = UF_REG_W,
    parameter int CNT_W        = UF_CNT_W,
    parameter int MPS_W        = UF_MPS_W,
    parameter int FRN_W        = UF_FRN_W,
    parameter int LS_W         = UF_LS_W,
    parameter int RST_INTERVAL = 11999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             bit_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] interval_rd,
    output logic [REG_W-1:0] remain_rd,
    output logic [FRN_W-1:0] frnum_rd,
    output logic             sof_pulse,
    output logic             fno_pulse,
    output logic             periodic_win,
    output logic             ls_ok
);
    localparam int GAP_W = REG_W - 1 - MPS_W - CNT_W;
    localparam int PAD_W = REG_W - 1 - CNT_W;

    logic [CNT_W-1:0] interval;
    logic [MPS_W-1:0] max_pkt;
    logic             intv_tog;
    logic [CNT_W-1:0] pstart;
    logic [LS_W-1:0]  ls_thr;
    logic [CNT_W-1:0] remain;
    logic             rem_tog;
    logic             reload_evt;

    ufrm_cfg_regs #(
        .REG_W(REG_W), .CNT_W(CNT_W), .MPS_W(MPS_W), .LS_W(LS_W),
        .RST_INTERVAL(RST_INTERVAL)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .interval(interval), .max_pkt(max_pkt),
        .intv_tog(intv_tog), .pstart(pstart), .ls_thr(ls_thr)
    );

    ufrm_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
        .interval(interval), .intv_tog(intv_tog), .remain(remain),
        .rem_tog(rem_tog), .reload_evt(reload_evt), .sof_pulse(sof_pulse)
    );

    ufrm_frnum #(.FRN_W(FRN_W)) u_frn (
        .clk(clk), .rst_n(rst_n), .advance(reload_evt),
        .frnum(frnum_rd), .fno_pulse(fno_pulse)
    );

    ufrm_cmp #(.CNT_W(CNT_W), .LS_W(LS_W)) u_cmp (
        .remain(remain), .pstart(pstart), .ls_thr(ls_thr),
        .periodic_win(periodic_win), .ls_ok(ls_ok)
    );

    // Pack the software-visible words.
    assign interval_rd = {intv_tog, max_pkt, {GAP_W{1'b0}}, interval};
    assign remain_rd   = {rem_tog, {PAD_W{1'b0}}, remain};
endmodule

// File: rtl/ufrm_timer_chk.sv
`timescale 1ns/1ps
// Port-level checker for the frame timer, bound to every instance.
module ufrm_timer_chk #(
    parameter int REG_W = 32,
    parameter int CNT_W = 14,
    parameter int FRN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             bit_tick,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [REG_W-1:0] interval_rd,
    input logic [REG_W-1:0] remain_rd,
    input logic [FRN_W-1:0] frnum_rd,
    input logic             sof_pulse,
    input logic             fno_pulse
);
    assert_sof_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (frnum_rd == $past(frnum_rd) + FRN_W'(1)));

    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (remain_rd[CNT_W-1:0] == $past(interval_rd[CNT_W-1:0])
                       && remain_rd[REG_W-1] == $past(interval_rd[REG_W-1])));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && bit_tick && remain_rd[CNT_W-1:0] != '0) |=>
        (remain_rd[CNT_W-1:0] == $past(remain_rd[CNT_W-1:0]) - CNT_W'(1)));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(remain_rd) && $stable(frnum_rd) && !sof_pulse));

    assert_fno_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fno_pulse |-> (sof_pulse && frnum_rd[FRN_W-2:0] == '0));

    assert_no_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> $stable(interval_rd));
endmodule

bind ufrm_timer ufrm_timer_chk #(
    .REG_W(REG_W), .CNT_W(CNT_W), .FRN_W(FRN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .interval_rd(interval_rd),
    .remain_rd(remain_rd), .frnum_rd(frnum_rd), .sof_pulse(sof_pulse),
    .fno_pulse(fno_pulse)
);

// File: tb/ufrm_timer_test.sv
`timescale 1ns/1ps
// Self-checking bench for the frame timer.
module ufrm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] interval_rd;
    logic [31:0] remain_rd;
    logic [15:0] frnum_rd;
    logic        sof_pulse;
    logic        fno_pulse;
    logic        periodic_win;
    logic        ls_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ufrm_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .interval_rd(interval_rd), .remain_rd(remain_rd), .frnum_rd(frnum_rd),
        .sof_pulse(sof_pulse), .fno_pulse(fno_pulse),
        .periodic_win(periodic_win), .ls_ok(ls_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive inputs, take the edge, sample 1 ns after it.
    task automatic cyc(input logic t, input logic we, input logic [1:0] sel,
                       input logic [31:0] d);
        bit_tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        bit_tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic tick(); cyc(1'b1, 1'b0, 2'd0, 32'h0); endtask
    task automatic idle(); cyc(1'b0, 1'b0, 2'd0, 32'h0); endtask
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cyc(1'b0, 1'b1, sel, d);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int fno_count;
        logic [15:0] exp_fn;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 remain", remain_rd, 32'h0);
        chk("R1 frnum", {16'h0, frnum_rd}, 32'h0);
        chk("R1 interval", interval_rd, 32'd11999);
        chk("R1 flags", {28'h0, sof_pulse, fno_pulse, periodic_win, ls_ok}, 32'h0);

        // R5 ticks ignored while disabled
        tick(); tick(); tick();
        chk("R5 remain frozen", remain_rd, 32'h0);
        chk("R5 frnum frozen", {16'h0, frnum_rd}, 32'h0);
        chk("R5 no sof", {31'h0, sof_pulse}, 32'h0);

        // R2 interval fields, bits 15:14 read as zero
        wr(2'd0, 32'h9234C009);
        chk("R2 interval word", interval_rd, 32'h92340009);
        wr(2'd1, 32'h00000005);
        wr(2'd2, 32'h00000007);

        // R3 first reload
        run_en = 1'b1;
        tick();
        chk("R3 reload remain+toggle", remain_rd, 32'h80000009);
        chk("R3 frnum", {16'h0, frnum_rd}, 32'd1);
        chk("R3 sof high", {31'h0, sof_pulse}, 32'd1);
        chk("R9 ls_ok at 9>7", {31'h0, ls_ok}, 32'd1);
        idle();
        chk("R3 sof one cycle", {31'h0, sof_pulse}, 32'd0);
        chk("R4 hold without tick", remain_rd, 32'h80000009);

        // R4 R8 R9 sweep across a full frame
        for (int k = 1; k <= 10; k++) begin
            int r;
            r = (k <= 9) ? 9 - k : 9;
            tick();
            chk("R4 count", {18'h0, remain_rd[13:0]}, r);
            chk("R8 periodic_win", {31'h0, periodic_win}, (r < 5) ? 1 : 0);
            chk("R9 ls_ok", {31'h0, ls_ok}, (r > 7) ? 1 : 0);
            chk("R3 sof", {31'h0, sof_pulse}, (k == 10) ? 1 : 0);
        end
        chk("R3 frnum after 2 frames", {16'h0, frnum_rd}, 32'd2);

        // R6 mid-frame write leaves count untouched
        tick(); tick(); tick();
        wr(2'd0, 32'h00000004);
        chk("R6 midframe write", remain_rd, 32'h80000006);
        for (int k = 0; k < 6; k++) tick();
        chk("R6 at zero", remain_rd, 32'h80000000);
        // R6 write on the reload edge: old value wins
        cyc(1'b1, 1'b1, 2'd0, 32'h80000002);
        chk("R6 reload uses prior interval", remain_rd, 32'h00000004);
        chk("R6 new interval stored", interval_rd, 32'h80000002);
        for (int k = 0; k < 5; k++) tick();
        chk("R6 next reload uses new interval", remain_rd, 32'h80000002);
        chk("R3 frnum 4", {16'h0, frnum_rd}, 32'd4);

        // R10 no-target write
        wr(2'd3, 32'hFFFFFFFF);
        chk("R10 interval kept", interval_rd, 32'h80000002);
        chk("R10 pstart kept", {31'h0, periodic_win}, 32'd1);
        chk("R10 lsthr kept", {31'h0, ls_ok}, 32'd0);

        // R5 freeze mid-frame
        run_en = 1'b0;
        tick(); tick(); tick();
        chk("R5 midframe remain", remain_rd, 32'h80000002);
        chk("R5 midframe frnum", {16'h0, frnum_rd}, 32'd4);
        run_en = 1'b1;

        // R8 R9 strict boundaries at remain 2
        wr(2'd1, 32'hFFFFC002);
        chk("R8 equal not below", {31'h0, periodic_win}, 32'd0);
        wr(2'd1, 32'h00000003);
        chk("R8 one above", {31'h0, periodic_win}, 32'd1);
        wr(2'd2, 32'hFFFFF002);
        chk("R9 equal not above", {31'h0, ls_ok}, 32'd0);
        wr(2'd2, 32'h00000001);
        chk("R9 one below", {31'h0, ls_ok}, 32'd1);

        // R7 frame number walk with one frame per tick
        wr(2'd0, 32'h00000000);
        tick(); tick();
        chk("R7 pre-walk remain", remain_rd, 32'h80000000);
        exp_fn = 16'd4;
        fno_count = 0;
        for (int i = 0; i < 65540; i++) begin
            tick();
            exp_fn = exp_fn + 16'd1;
            if (fno_pulse) fno_count++;
            if (exp_fn == 16'h8000 || exp_fn == 16'h0000 || exp_fn == 16'h7FFF ||
                exp_fn == 16'hFFFF || exp_fn[11:0] == 12'h0) begin
                chk("R7 fno", {31'h0, fno_pulse},
                    (exp_fn == 16'h8000 || exp_fn == 16'h0000) ? 1 : 0);
                chk("R3 frnum walk", {16'h0, frnum_rd}, {16'h0, exp_fn});
                chk("R3 sof each frame", {31'h0, sof_pulse}, 32'd1);
            end
        end
        chk("R7 two pulses", fno_count, 32'd2);
        idle();
        chk("R7 pulse ends", {31'h0, fno_pulse}, 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule